// File: doc/BRIEF.md
# Two-Wire Control Register Slave with Indexed and Sequential Access

This block is a serial slave on a two-wire bus. It gives a host read and write access to eight 8-bit control registers of a clock synthesizer. The block runs on a fast system clock. The bus clock and data lines arrive as raw inputs and are oversampled through synchronizers. The data line is driven only low, through an output-enable (`sda_oe` high pulls the line to ground).

After the address, the first byte the host sends is a command byte. It picks one of two access styles:
- **Indexed single-byte access:** the command carries a register offset.
- **Sequential block access:** transfers start at offset 0 and climb upward. A byte count travels in both directions. The host sends a count ahead of write data. The slave returns a count of 8 ahead of read data.

The register contents are decoded into control outputs: four output enables, a spread-depth select, a spread enable, an output-frequency select and two test-mode bits.

The controller is a single state machine:
- **S_IDLE:** waits for a start condition.
- **S_ADDR:** takes in the address byte. On a match it goes to S_ACK; on a mismatch it goes to S_SKIP.
- **S_CMD:** decodes the command byte. It goes to S_ACK, then on to S_WCNT (block command) or S_WDATA (byte command). A bad command goes to S_SKIP.
- **S_WCNT:** absorbs the byte count, then goes through S_ACK to S_WDATA.
- **S_WDATA:** writes each byte and returns to itself through S_ACK.
- **S_ACK:** pulls the data line low for the ninth slot, then jumps to the stored follow-on state.
- **S_TX:** shifts a byte out.
- **S_TXACK:** samples the host's acknowledge. An acknowledge goes back to S_TX; a not-acknowledge goes to S_SKIP.
- **S_SKIP:** ignores the bus.

From any state, a start condition enters S_ADDR and a stop condition enters S_IDLE.

Top module: `ctlreg_twi_slave`

## Requirements
- R1: The slave acknowledges only the 7-bit address 0x69, which is 0xD2 as a write and 0xD3 as a read. Any other address is not acknowledged. After a foreign address, every byte up to the next start is not acknowledged and has no effect.
- R2: Command byte fields:
  - Bit 7 = 1 selects single-byte access; bit 7 = 0 selects block access.
  - Bits 6:5 must be 00.
  - Bits 4:0 are the offset in byte mode and must be 0 in block mode.
  
  A command with bits 6:5 not 00, or a block command with a nonzero offset, is not acknowledged. The bus is then ignored until the next start.
- R3: Byte write: start, 0xD2, command, one data byte, stop. The data byte is stored at the indexed offset, and every byte is acknowledged.
- R4: Byte read: start, 0xD2, command, repeated start, 0xD3. The slave then returns the byte at the indexed offset, most significant bit first, and the host ends with not-acknowledge and stop.
- R5: Block write: command 0x00, a byte count, then data bytes that fill offsets 0, 1, 2 and so on. A stop after any complete byte keeps all bytes already received.
- R6: Block read: command 0x00, repeated start, 0xD3. The slave returns a count of 8 and then bytes from offset 0 upward, for as long as the host acknowledges.
- R7: Offset 7 is read-only. Writes to offsets 7 and above are acknowledged but change nothing. Reads above offset 7 return 0x00.
- R8: Reset values by offset 0 to 7 are 7C, 00, EB, AF, 01, 00, 13, 01. The decoded outputs are:
  - `out_en[3:0]` is register 0 bits 6:3.
  - `spread_sel` is register 2 bit 7.
  - `spread_en` is register 2 bit 2.
  - `freq_sel` is register 2 bit 0.
  - `test_ref_sel` is register 6 bit 7.
  - `test_mode` is register 6 bit 6.
- R9: The slave changes `sda_oe` only while the bus clock is low. It works with a bus clock near 400 kHz on a 50 MHz system clock, which is about 31 system clocks per quarter bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Raw bus clock line |
| sda_i | input | 1 | Raw bus data line |
| sda_oe | output | 1 | High pulls the data line low |
| out_en | output | 4 | Output enables, bit 3 for output 4 |
| spread_sel | output | 1 | Spread depth: 0 = -0.35 %, 1 = -0.5 % |
| spread_en | output | 1 | Spread modulation on |
| freq_sel | output | 1 | Output frequency: 0 = 100 MHz, 1 = 200 MHz |
| test_mode | output | 1 | Test clock mode entered |
| test_ref_sel | output | 1 | In test mode: 0 = high-impedance, 1 = divided reference |

## Verification
The bench targets the following corner cases:
- **Read-only byte and offsets past the end.** A design that wrapped the pointer or wrote offset 7 would corrupt the first registers or the vendor byte. One that did not acknowledge writes past the end would stall the host.
- **Byte count ahead of block data.** A design that forgot the count would show every block read shifted by one byte.
- **Block write stopped after three bytes.** This catches a design that commits data only at the end of a transfer.
- **Foreign addresses and illegal commands.** A design that resumed listening too early would acknowledge the trailing data bytes or let them change registers.

A bus monitor flags any change of the pull-down while the bus clock is high, which a misplaced shift or acknowledge would cause.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;

    localparam int NREG      = 8;      // control registers
    localparam int PTR_W     = 5;      // offset field width in the command
    localparam int IDX_W     = $clog2(NREG);
    localparam int RO_IDX    = 7;      // identification byte, read-only
    localparam int NOUT      = 4;      // output-enable bits
    localparam int SYNC_N    = 2;      // synchronizer depth
    localparam logic [6:0] DEV_ADDR  = 7'h69;
    localparam logic [7:0] BLK_COUNT = 8'(NREG);

    typedef enum logic [3:0] {
        S_IDLE,
        S_ADDR,
        S_CMD,
        S_WCNT,
        S_WDATA,
        S_ACK,
        S_TX,
        S_TXACK,
        S_SKIP
    } twi_state_e;

    function automatic logic [7:0] reg_default(input int idx);
        case (idx)
            0:       return 8'h7C;
            1:       return 8'h00;
            2:       return 8'hEB;
            3:       return 8'hAF;
            4:       return 8'h01;
            5:       return 8'h00;
            6:       return 8'h13;
            7:       return 8'h01;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/twi_sync.sv
module twi_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);

    // STAGES flops of synchronization plus one for edge history
    logic [STAGES:0] scl_pipe;
    logic [STAGES:0] sda_pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-1:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-1:0], sda_i};
        end
    end

    logic scl_q, sda_q;
    assign scl_s = scl_pipe[STAGES-1];
    assign sda_s = sda_pipe[STAGES-1];
    assign scl_q = scl_pipe[STAGES];
    assign sda_q = sda_pipe[STAGES];

    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign bus_start = scl_s & scl_q & sda_q & ~sda_s;
    assign bus_stop  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/ctlreg_bank.sv
module ctlreg_bank
    import ctlreg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] wr_addr,
    input  logic [7:0]       wr_data,
    input  logic [PTR_W-1:0] rd_addr,
    output logic [7:0]       rd_data,
    output logic [NOUT-1:0]  out_en,
    output logic             spread_sel,
    output logic             spread_en,
    output logic             freq_sel,
    output logic             test_mode,
    output logic             test_ref_sel
);

    localparam logic [PTR_W-1:0] NREG_P = PTR_W'(NREG);
    localparam logic [PTR_W-1:0] RO_P   = PTR_W'(RO_IDX);

    logic [NREG-1:0][7:0] reg_q;

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        localparam logic [7:0] DEF = reg_default(i);
        if (i == RO_IDX) begin : g_ro
            assign reg_q[i] = DEF;
        end else begin : g_rw
            logic [7:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    q <= DEF;
                else if (wr_en && wr_addr == PTR_W'(i))
                    q <= wr_data;
            end
            assign reg_q[i] = q;
        end
    end

    assign rd_data = (rd_addr < NREG_P) ? reg_q[rd_addr[IDX_W-1:0]] : 8'h00;

    assign out_en       = reg_q[0][3 +: NOUT];
    assign spread_sel   = reg_q[2][7];
    assign spread_en    = reg_q[2][2];
    assign freq_sel     = reg_q[2][0];
    assign test_ref_sel = reg_q[6][7];
    assign test_mode    = reg_q[6][6];

    // R3: a write to a writable offset is visible on the next cycle
    a_r3_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr < NREG_P && wr_addr != RO_P)
        |=> (reg_q[$past(wr_addr[IDX_W-1:0])] == $past(wr_data)));

    // R7: writes to the read-only byte or past the end leave the bank untouched
    a_r7_ignored_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr >= NREG_P || wr_addr == RO_P)) |=> $stable(reg_q));

endmodule

// File: rtl/ctlreg_twi_slave.sv
module ctlreg_twi_slave
    import ctlreg_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            scl_i,
    input  logic            sda_i,
    output logic            sda_oe,
    output logic [NOUT-1:0] out_en,
    output logic            spread_sel,
    output logic            spread_en,
    output logic            freq_sel,
    output logic            test_mode,
    output logic            test_ref_sel
);

    logic scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;

    twi_sync #(.STAGES(SYNC_N)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .bus_start (bus_start),
        .bus_stop  (bus_stop)
    );

    twi_state_e       st, nxt_st;
    logic [3:0]       bitcnt;
    logic [7:0]       shreg;
    logic [PTR_W-1:0] ptr;
    logic             cnt_pend;
    logic             ack_ph;
    logic             m_ack;

    logic [7:0] rx_byte, rd_data, tx_next;
    logic       byte_end, wr_en;

    assign rx_byte  = {shreg[6:0], sda_s};
    assign byte_end = scl_rise && (bitcnt == 4'd7);
    assign tx_next  = cnt_pend ? BLK_COUNT : rd_data;

    ctlreg_bank u_bank (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_addr      (ptr),
        .wr_data      (rx_byte),
        .rd_addr      (ptr),
        .rd_data      (rd_data),
        .out_en       (out_en),
        .spread_sel   (spread_sel),
        .spread_en    (spread_en),
        .freq_sel     (freq_sel),
        .test_mode    (test_mode),
        .test_ref_sel (test_ref_sel)
    );

    // state register and byte datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st       <= S_IDLE;
            nxt_st   <= S_IDLE;
            bitcnt   <= '0;
            shreg    <= '0;
            ptr      <= '0;
            cnt_pend <= 1'b0;
            ack_ph   <= 1'b0;
            m_ack    <= 1'b0;
        end else if (bus_stop) begin
            st     <= S_IDLE;
            ack_ph <= 1'b0;
        end else if (bus_start) begin
            st     <= S_ADDR;
            bitcnt <= '0;
            ack_ph <= 1'b0;
        end else begin
            unique case (st)
                S_IDLE, S_SKIP: ;
                S_ADDR, S_CMD, S_WCNT, S_WDATA: begin
                    if (scl_rise) begin
                        shreg  <= rx_byte;
                        bitcnt <= bitcnt + 4'd1;
                    end
                    if (byte_end) begin
                        bitcnt <= '0;
                        st     <= S_ACK;
                        if (st == S_ADDR) begin
                            if (rx_byte[7:1] != DEV_ADDR)
                                st <= S_SKIP;
                            nxt_st <= rx_byte[0] ? S_TX : S_CMD;
                        end else if (st == S_CMD) begin
                            if (rx_byte[6:5] != 2'b00 ||
                                (!rx_byte[7] && rx_byte[4:0] != 5'd0)) begin
                                st <= S_SKIP;
                            end else begin
                                ptr      <= rx_byte[PTR_W-1:0];
                                cnt_pend <= !rx_byte[7];
                                nxt_st   <= rx_byte[7] ? S_WDATA : S_WCNT;
                            end
                        end else if (st == S_WCNT) begin
                            cnt_pend <= 1'b0;
                            nxt_st   <= S_WDATA;
                        end else begin
                            if (ptr != '1)
                                ptr <= ptr + 1'b1;
                            nxt_st <= S_WDATA;
                        end
                    end
                end
                S_ACK: begin
                    if (scl_fall) begin
                        if (!ack_ph) begin
                            ack_ph <= 1'b1;
                        end else begin
                            ack_ph <= 1'b0;
                            st     <= nxt_st;
                            bitcnt <= '0;
                            if (nxt_st == S_TX)
                                shreg <= tx_next;
                        end
                    end
                end
                S_TX: begin
                    if (scl_rise)
                        bitcnt <= bitcnt + 4'd1;
                    if (scl_fall) begin
                        if (bitcnt == 4'd8) begin
                            st     <= S_TXACK;
                            bitcnt <= '0;
                            m_ack  <= 1'b0;
                        end else begin
                            shreg <= {shreg[6:0], 1'b0};
                        end
                    end
                end
                S_TXACK: begin
                    if (scl_rise) begin
                        if (sda_s) begin
                            st <= S_SKIP;
                        end else begin
                            m_ack <= 1'b1;
                            if (cnt_pend)
                                cnt_pend <= 1'b0;
                            else if (ptr != '1)
                                ptr <= ptr + 1'b1;
                        end
                    end
                    if (scl_fall && m_ack) begin
                        st    <= S_TX;
                        shreg <= tx_next;
                        m_ack <= 1'b0;
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        sda_oe = 1'b0;
        wr_en  = 1'b0;
        unique case (st)
            S_ACK:   sda_oe = ack_ph;
            S_TX:    sda_oe = !shreg[7];
            S_WDATA: wr_en  = byte_end && !bus_start && !bus_stop;
            default: ;
        endcase
    end

    // R9: the pull-down only moves while the synchronized bus clock is low
    a_r9_sda_moves_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_s);

    // R1: a foreign address sends the machine to the ignore state
    a_r1_foreign_skip: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_ADDR && byte_end && rx_byte[7:1] != DEV_ADDR) |=> (st == S_SKIP));

    // R2: a command with a nonzero chip-select field is refused
    a_r2_bad_cs_skip: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_CMD && byte_end && rx_byte[6:5] != 2'b00) |=> (st == S_SKIP));

endmodule

// File: tb/test_ctlreg_twi_slave.sv
module test_ctlreg_twi_slave;

    localparam int Q = 31;   // system clocks per quarter bit

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe, spread_sel, spread_en, freq_sel, test_mode, test_ref_sel;
    logic [3:0] out_en;
    logic sda_bus;

    assign sda_bus = sda_m & ~sda_oe;

    always #10 clk = ~clk;   // 50 MHz

    ctlreg_twi_slave i_ctlreg_twi_slave (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_i        (scl_m),
        .sda_i        (sda_bus),
        .sda_oe       (sda_oe),
        .out_en       (out_en),
        .spread_sel   (spread_sel),
        .spread_en    (spread_en),
        .freq_sel     (freq_sel),
        .test_mode    (test_mode),
        .test_ref_sel (test_ref_sel)
    );

    int n_tests = 0;
    int n_fail  = 0;
    int viol    = 0;
    bit done    = 0;
    logic [7:0] rbuf [0:15];

    // offset, data written, value expected back
    localparam logic [20:0] VEC [7] = '{
        {5'd0, 8'h55, 8'h55},
        {5'd2, 8'h05, 8'h05},
        {5'd6, 8'hC0, 8'hC0},
        {5'd7, 8'hFF, 8'h01},
        {5'd9, 8'hAA, 8'h00},
        {5'd3, 8'h3C, 8'h3C},
        {5'd1, 8'h81, 8'h81}
    };

    // R9 monitor: pull-down must not change while the bus clock is high
    logic oe_prev = 1'b0;
    always @(negedge clk) begin
        if (rst_n && scl_m && sda_oe !== oe_prev) viol++;
        oe_prev <= sda_oe;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wait_q();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_q();
        scl_m = 1'b1; wait_q();
        sda_m = 1'b0; wait_q();
        scl_m = 1'b0; wait_q();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_q();
        scl_m = 1'b1; wait_q();
        sda_m = 1'b1; wait_q();
    endtask

    task automatic put_bit(input logic b);
        sda_m = b;    wait_q();
        scl_m = 1'b1; wait_q(); wait_q();
        scl_m = 1'b0; wait_q();
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; wait_q();
        scl_m = 1'b1; wait_q();
        b = sda_bus;  wait_q();
        scl_m = 1'b0; wait_q();
    endtask

    task automatic wr_byte(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(d[i]);
        get_bit(b);
        ack = !b;
    endtask

    task automatic rd_byte(output logic [7:0] d, input logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            d[i] = b;
        end
        put_bit(!ack);
    endtask

    task automatic byte_write(input logic [4:0] off, input logic [7:0] d, output logic all_ack);
        logic a0, a1, a2;
        bus_start();
        wr_byte(8'hD2, a0);
        wr_byte({3'b100, off}, a1);
        wr_byte(d, a2);
        bus_stop();
        all_ack = a0 & a1 & a2;
    endtask

    task automatic byte_read(input logic [4:0] off, output logic [7:0] d, output logic all_ack);
        logic a0, a1, a2;
        bus_start();
        wr_byte(8'hD2, a0);
        wr_byte({3'b100, off}, a1);
        bus_start();
        wr_byte(8'hD3, a2);
        rd_byte(d, 1'b0);
        bus_stop();
        all_ack = a0 & a1 & a2;
    endtask

    // count plus n-1 data bytes land in rbuf[0..n-1]
    task automatic blk_read(input int n, output logic all_ack);
        logic a0, a1, a2;
        bus_start();
        wr_byte(8'hD2, a0);
        wr_byte(8'h00, a1);
        bus_start();
        wr_byte(8'hD3, a2);
        for (int i = 0; i < n; i++) rd_byte(rbuf[i], i != n - 1);
        bus_stop();
        all_ack = a0 & a1 & a2;
    endtask

    task automatic report();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        logic ack;
        logic [7:0] d;
        logic [7:0] defs [0:7];
        defs = '{8'h7C, 8'h00, 8'hEB, 8'hAF, 8'h01, 8'h00, 8'h13, 8'h01};

        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R8 reset state of the decoded outputs
        chk("R8 out_en reset", 32'(out_en), 32'hF);
        chk("R8 spread_sel reset", 32'(spread_sel), 32'd1);
        chk("R8 spread_en reset", 32'(spread_en), 32'd0);
        chk("R8 freq_sel reset", 32'(freq_sel), 32'd1);
        chk("R8 test bits reset", 32'({test_ref_sel, test_mode}), 32'd0);
        chk("R9 idle line released", 32'(sda_oe), 32'd0);

        // R6 block read of the reset contents: count first, then offsets 0..7
        blk_read(9, ack);
        chk("R6 block read acks", 32'(ack), 32'd1);
        chk("R6 byte count", 32'(rbuf[0]), 32'd8);
        for (int i = 0; i < 8; i++)
            chk($sformatf("R8 default byte %0d", i), 32'(rbuf[i+1]), 32'(defs[i]));

        // R3 R4 R7 R9 table of byte writes followed by byte reads
        for (int k = 0; k < 7; k++) begin
            byte_write(VEC[k][20:16], VEC[k][15:8], ack);
            chk($sformatf("R3 R7 write ack off %0d", VEC[k][20:16]), 32'(ack), 32'd1);
            byte_read(VEC[k][20:16], d, ack);
            chk($sformatf("R4 read ack off %0d", VEC[k][20:16]), 32'(ack), 32'd1);
            chk($sformatf("R4 R7 R9 readback off %0d", VEC[k][20:16]), 32'(d), 32'(VEC[k][7:0]));
        end

        // R8 decoded outputs after the table writes
        chk("R8 out_en from 0x55", 32'(out_en), 32'hA);
        chk("R8 spread and freq from 0x05", 32'({spread_sel, spread_en, freq_sel}), 32'b011);
        chk("R8 test bits from 0xC0", 32'({test_ref_sel, test_mode}), 32'b11);

        // R1 foreign address: nothing acknowledged until the next start
        bus_start();
        wr_byte(8'hA4, ack);
        chk("R1 foreign address nack", 32'(ack), 32'd0);
        wr_byte(8'h80, ack);
        chk("R1 trailing byte nack", 32'(ack), 32'd0);
        wr_byte(8'h00, ack);
        chk("R1 trailing data nack", 32'(ack), 32'd0);
        bus_stop();
        byte_read(5'd0, d, ack);
        chk("R1 register untouched", 32'(d), 32'h55);

        // R2 bad chip-select field, then a data byte that must be ignored
        bus_start();
        wr_byte(8'hD2, ack);
        wr_byte(8'hA0, ack);
        chk("R2 bad chip select nack", 32'(ack), 32'd0);
        wr_byte(8'h00, ack);
        chk("R2 ignored data nack", 32'(ack), 32'd0);
        bus_stop();
        byte_read(5'd0, d, ack);
        chk("R2 register untouched", 32'(d), 32'h55);

        // R2 block command with a nonzero offset
        bus_start();
        wr_byte(8'hD2, ack);
        wr_byte(8'h02, ack);
        chk("R2 block offset nack", 32'(ack), 32'd0);
        bus_stop();

        // R5 block write stopped after three data bytes
        bus_start();
        wr_byte(8'hD2, ack);
        wr_byte(8'h00, ack);
        chk("R5 block command ack", 32'(ack), 32'd1);
        wr_byte(8'h08, ack);
        chk("R5 count ack", 32'(ack), 32'd1);
        wr_byte(8'h11, ack);
        wr_byte(8'h22, ack);
        wr_byte(8'h33, ack);
        chk("R5 data ack", 32'(ack), 32'd1);
        bus_stop();
        blk_read(5, ack);
        chk("R6 short block read count", 32'(rbuf[0]), 32'd8);
        chk("R5 offset 0", 32'(rbuf[1]), 32'h11);
        chk("R5 offset 1", 32'(rbuf[2]), 32'h22);
        chk("R5 offset 2", 32'(rbuf[3]), 32'h33);
        chk("R5 offset 3 kept", 32'(rbuf[4]), 32'h3C);
        chk("R5 R8 out_en from 0x11", 32'(out_en), 32'h2);

        // R7 full block write running past the end
        bus_start();
        wr_byte(8'hD2, ack);
        wr_byte(8'h00, ack);
        wr_byte(8'h09, ack);
        for (int i = 0; i < 9; i++) wr_byte(8'hA0 + 8'(i), ack);
        chk("R7 byte past end ack", 32'(ack), 32'd1);
        bus_stop();
        blk_read(9, ack);
        for (int i = 0; i < 7; i++)
            chk($sformatf("R5 block byte %0d", i), 32'(rbuf[i+1]), 32'(8'hA0 + 8'(i)));
        chk("R7 read-only byte kept", 32'(rbuf[8]), 32'h01);

        chk("R9 line changed while clock high", viol, 0);

        done = 1;
        report();
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            report();
        end
    end

endmodule